// File: doc/BRIEF.md
# Touch-Screen ADC Conversion Sequencer

This block runs a serial 12-bit touch-screen converter without processor help. Everything runs in the master clock domain. The block makes the converter's data clock in one of two ways. It can divide the master clock by a selectable ratio of 10 or 20. It can also follow an external clock pin after synchronizing it. The block then frames conversions back to back without stopping. Each frame drops chip select, and the block sends an 8-bit command on the serial data-in line during the first eight data-clock periods of that frame.

After the command, the converter spends one busy clock. It then returns a 12-bit result on its serial output, most significant bit first. The sequencer collects these bits and copies the finished word to a parallel output register. At the same moment it raises a data-valid strobe for one data-clock period. Two frame lengths are available: 16 and 24 clocks. In the short mode, chip select stays low and each new command overlaps the tail of the previous result. In the long mode, every frame is followed by a one-clock idle gap with chip select high. A 32 MHz master clock divided by 10 gives a 3.2 MHz data clock, and in the short mode that gives 200 k conversions per second.

Top module: `tsadc_seq`

## Requirements
- R1: While `rst_i` is high at a master clock edge, the block drives `cs_n_o` high and holds `dclk_o`, `adc_din_o`, `dvalid_o` and `result_o` at zero.
- R2: With `ext_sel_i` low, the data clock comes from the master clock. When `div_hi_i` is 0, each period lasts 10 master clocks, 5 high and then 5 low. When `div_hi_i` is 1, each period lasts 20 master clocks, 10 high and 10 low.
- R3: With `ext_sel_i` high, `dclk_o` takes the level of `ext_clk_i` on the third master clock rising edge after the input changes.
- R4: The command goes out on `adc_din_o` most significant bit first, `cmd_i[7]` before `cmd_i[0]`. Bit 7 is the start bit, bits 6..4 are the channel address, bit 3 is the conversion mode, bit 2 is single-ended/differential, and bits 1..0 are power-down. The line changes only on falling edges of the data clock, carries one command bit in each of frame slots 0..7, and is low for all later slots.
- R5: `cmd_i` is loaded when a frame starts, on the falling edge that opens slot 0. A change made later in that frame does not affect that frame and is used by the next one.
- R6: The result is sampled from `adc_dout_i` on the data-clock rising edges of slots 9 through 20 of a frame, B11 first. The finished word appears on `result_o` with B11 as bit 11.
- R7: `dvalid_o` rises on the data-clock rising edge that samples B0 and stays high for exactly one data-clock period. `result_o` changes only at that edge and holds its value until the next one.
- R8: With `frame_long_i` low, a frame lasts 16 data clocks. Chip select stays low from the first frame onward, and the next command starts in the slot right after slot 15.
- R9: With `frame_long_i` high, chip select stays low for 24 data clocks. It then goes high for one data-clock period and falls again at the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ext_sel_i | input | 1 | 1: data clock follows ext_clk_i; 0: divided master clock |
| div_hi_i | input | 1 | Divide ratio select: 0 for 10, 1 for 20 |
| ext_clk_i | input | 1 | External data clock source |
| frame_long_i | input | 1 | 0: 16-clock frames; 1: 24-clock frames with idle gap |
| cmd_i | input | 8 | Command byte sent in each frame |
| adc_dout_i | input | 1 | Serial result from the converter |
| dclk_o | output | 1 | Data clock to the converter |
| cs_n_o | output | 1 | Chip select, active low |
| adc_din_o | output | 1 | Serial command to the converter |
| result_o | output | 12 | Last complete conversion result |
| dvalid_o | output | 1 | One data-clock-wide pulse when result_o is updated |

## Verification
Every output of the sequencer is registered. A data-clock edge and the changes on chip select, the command line and the result all appear at the same master clock edge. The external clock appears on `dclk_o` three master edges after the input changes. The bench therefore waits on the `dclk_o` edges themselves and samples one nanosecond after them. It compares the command bit right after each falling edge. It drives result bits just after each falling edge, so they are stable at the following rising edge. It expects `dvalid_o` and the new word at the falling edge that opens slot 21, and expects the strobe to be gone one falling edge later. The divider test counts master clock edges between `dclk_o` transitions. The external-clock test checks that the level has not arrived after two edges and has arrived after three.

// File: rtl/tsadc_pkg.sv
`timescale 1ns/1ps
package tsadc_pkg;

    // Data-clock transition flags, valid in the cycle before dclk changes.
    typedef struct packed {
        logic rise;
        logic fall;
    } dclk_evt_t;

endpackage

// File: rtl/tsadc_clkgen.sv
`timescale 1ns/1ps
module tsadc_clkgen
    import tsadc_pkg::*;
#(
    parameter int DIV_LO      = 10,
    parameter int DIV_HI      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      ext_sel_i,
    input  logic      div_hi_i,
    input  logic      ext_clk_i,
    output logic      dclk_o,
    output dclk_evt_t evt_o
);

    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int CNT_W   = $clog2(DIV_MAX);
    localparam logic [CNT_W-1:0] LO_HALF = CNT_W'(DIV_LO / 2 - 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] HI_HALF = CNT_W'(DIV_HI / 2 - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(DIV_HI - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   dclk;
    } gen_st_t;

    gen_st_t st_q, st_d;
    logic [SYNC_STAGES-1:0] sync_nx;
    logic [CNT_W-1:0]       half_pt;
    logic [CNT_W-1:0]       last_pt;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            assign sync_nx = ext_clk_i;
        end else begin : g_sync_chain
            assign sync_nx = {st_q.sync[SYNC_STAGES-2:0], ext_clk_i};
        end
    endgenerate

    assign half_pt = div_hi_i ? HI_HALF : LO_HALF;
    assign last_pt = div_hi_i ? HI_LAST : LO_LAST;

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_nx;
        if (ext_sel_i) begin
            st_d.cnt  = '0;
            st_d.dclk = st_q.sync[SYNC_STAGES-1];
        end else if (st_q.cnt >= last_pt) begin
            st_d.cnt  = '0;
            st_d.dclk = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == half_pt) begin
                st_d.dclk = 1'b1;
            end
        end
        evt_o.rise = st_d.dclk & ~st_q.dclk;
        evt_o.fall = ~st_d.dclk & st_q.dclk;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dclk_o = st_q.dclk;

endmodule

// File: rtl/tsadc_tx.sv
`timescale 1ns/1ps
module tsadc_tx #(
    parameter int CMD_W     = 8,
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 24,
    parameter int SLOT_W    = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fall_i,
    input  logic              frame_long_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic              cs_n_o,
    output logic              din_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              in_frame_o
);

    localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_LEN - 1);
    localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(LONG_LEN - 1);
    localparam logic [SLOT_W-1:0] CMD_LAST   = SLOT_W'(CMD_W - 1);

    typedef struct packed {
        logic              cs_n;
        logic [SLOT_W-1:0] slot;
        logic [CMD_W-1:0]  sr;
        logic              din;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{cs_n: 1'b1, default: '0};

    tx_st_t st_q, st_d;
    logic [SLOT_W-1:0] frame_last;
    logic              open_frame;

    assign frame_last = frame_long_i ? LONG_LAST : SHORT_LAST;

    always_comb begin
        st_d       = st_q;
        open_frame = 1'b0;
        if (fall_i) begin
            if (st_q.cs_n) begin
                open_frame = 1'b1;
            end else if (st_q.slot >= frame_last) begin
                if (frame_long_i) begin
                    st_d.cs_n = 1'b1;
                    st_d.slot = '0;
                    st_d.din  = 1'b0;
                end else begin
                    open_frame = 1'b1;
                end
            end else begin
                st_d.slot = st_q.slot + 1'b1;
                if (st_q.slot < CMD_LAST) begin
                    st_d.din = st_q.sr[CMD_W-1];
                    st_d.sr  = {st_q.sr[CMD_W-2:0], 1'b0};
                end else begin
                    st_d.din = 1'b0;
                end
            end
            if (open_frame) begin
                st_d.cs_n = 1'b0;
                st_d.slot = '0;
                st_d.din  = cmd_i[CMD_W-1];
                st_d.sr   = {cmd_i[CMD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= TX_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n_o     = st_q.cs_n;
    assign din_o      = st_q.din;
    assign slot_o     = st_q.slot;
    assign in_frame_o = ~st_q.cs_n;

endmodule

// File: rtl/tsadc_rx.sv
`timescale 1ns/1ps
module tsadc_rx #(
    parameter int DATA_W     = 12,
    parameter int START_SLOT = 9,
    parameter int SLOT_W     = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rise_i,
    input  logic              in_frame_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              dout_i,
    output logic [DATA_W-1:0] result_o,
    output logic              dvalid_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [SLOT_W-1:0] FIRST_SL = SLOT_W'(START_SLOT);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] result;
        logic              dvalid;
    } rx_st_t;

    rx_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.dvalid = 1'b0;
            if (st_q.busy) begin
                st_d.sh = {st_q.sh[DATA_W-2:0], dout_i};
                if (st_q.cnt == LAST_BIT) begin
                    st_d.result = {st_q.sh[DATA_W-2:0], dout_i};
                    st_d.dvalid = 1'b1;
                    st_d.busy   = 1'b0;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (in_frame_i && slot_i == FIRST_SL) begin
                st_d.sh   = {st_q.sh[DATA_W-2:0], dout_i};
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign dvalid_o = st_q.dvalid;

endmodule

// File: rtl/tsadc_seq.sv
`timescale 1ns/1ps
module tsadc_seq
    import tsadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CMD_W       = 8,
    parameter int BUSY_CLKS   = 1,
    parameter int DIV_LO      = 10,
    parameter int DIV_HI      = 20,
    parameter int SHORT_LEN   = 16,
    parameter int LONG_LEN    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ext_sel_i,
    input  logic              div_hi_i,
    input  logic              ext_clk_i,
    input  logic              frame_long_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              adc_dout_i,
    output logic              dclk_o,
    output logic              cs_n_o,
    output logic              adc_din_o,
    output logic [DATA_W-1:0] result_o,
    output logic              dvalid_o
);

    localparam int SLOT_W     = $clog2(LONG_LEN);
    localparam int START_SLOT = CMD_W + BUSY_CLKS;

    dclk_evt_t         evt;
    logic [SLOT_W-1:0] slot;
    logic              in_frame;

    tsadc_clkgen #(
        .DIV_LO      (DIV_LO),
        .DIV_HI      (DIV_HI),
        .SYNC_STAGES (SYNC_STAGES)
    ) clkgen_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ext_sel_i (ext_sel_i),
        .div_hi_i  (div_hi_i),
        .ext_clk_i (ext_clk_i),
        .dclk_o    (dclk_o),
        .evt_o     (evt)
    );

    tsadc_tx #(
        .CMD_W     (CMD_W),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .SLOT_W    (SLOT_W)
    ) tx_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .fall_i       (evt.fall),
        .frame_long_i (frame_long_i),
        .cmd_i        (cmd_i),
        .cs_n_o       (cs_n_o),
        .din_o        (adc_din_o),
        .slot_o       (slot),
        .in_frame_o   (in_frame)
    );

    tsadc_rx #(
        .DATA_W     (DATA_W),
        .START_SLOT (START_SLOT),
        .SLOT_W     (SLOT_W)
    ) rx_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rise_i     (evt.rise),
        .in_frame_i (in_frame),
        .slot_i     (slot),
        .dout_i     (adc_dout_i),
        .result_o   (result_o),
        .dvalid_o   (dvalid_o)
    );

endmodule

// File: rtl/tsadc_seq_chk.sv
`timescale 1ns/1ps
module tsadc_seq_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              frame_long_i,
    input logic              dclk_o,
    input logic              cs_n_o,
    input logic              adc_din_o,
    input logic [DATA_W-1:0] result_o,
    input logic              dvalid_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (cs_n_o && !dclk_o && !adc_din_o && !dvalid_o && result_o == '0));

    // R4
    din_on_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(adc_din_o) |-> $fell(dclk_o));

    // R7
    dvalid_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dvalid_o) |-> $rose(dclk_o));

    // R7
    result_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(result_o) |-> $rose(dvalid_o));

    // R8
    short_cs_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!frame_long_i && !cs_n_o) |=> !cs_n_o);

    // R9
    cs_on_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(cs_n_o) |-> $fell(dclk_o));

endmodule

bind tsadc_seq tsadc_seq_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .frame_long_i (frame_long_i),
    .dclk_o       (dclk_o),
    .cs_n_o       (cs_n_o),
    .adc_din_o    (adc_din_o),
    .result_o     (result_o),
    .dvalid_o     (dvalid_o)
);

// File: tb/tsadc_seq_tb.sv
`timescale 1ns/1ps
module tsadc_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_sel = 1'b0;
    logic        div_hi = 1'b0;
    logic        ext_clk = 1'b0;
    logic        frame_long = 1'b0;
    logic [7:0]  cmd = 8'h97;
    logic        dout = 1'b0;
    logic        dclk, cs_n, din, dvalid;
    logic [11:0] result;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tsadc_seq dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .ext_sel_i    (ext_sel),
        .div_hi_i     (div_hi),
        .ext_clk_i    (ext_clk),
        .frame_long_i (frame_long),
        .cmd_i        (cmd),
        .adc_dout_i   (dout),
        .dclk_o       (dclk),
        .cs_n_o       (cs_n),
        .adc_din_o    (din),
        .result_o     (result),
        .dvalid_o     (dvalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // R1: state under reset
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(dclk == 1'b0 && din == 1'b0, "R1 dclk/din", int'({dclk, din}), 0);
        chk(dvalid == 1'b0, "R1 dvalid", int'(dvalid), 0);
        chk(result == 12'h000, "R1 result", int'(result), 0);
        rst = 1'b0;
    endtask

    // R2: divided data clock phases
    task automatic t_divider(input bit hi);
        int n;
        int half;
        half = hi ? 10 : 5;
        ext_sel = 1'b0;
        div_hi  = hi;
        do_reset();
        @(posedge dclk);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (dclk);
        chk(n == half, "R2 high phase", n, half);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!dclk);
        chk(n == half, "R2 low phase", n, half);
    endtask

    // R3: external clock follows after three master edges
    task automatic t_external();
        ext_sel = 1'b1;
        ext_clk = 1'b0;
        do_reset();
        @(negedge clk);
        ext_clk = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(dclk == 1'b0, "R3 rise too early", int'(dclk), 0);
        @(posedge clk);
        #1;
        chk(dclk == 1'b1, "R3 rise", int'(dclk), 1);
        @(negedge clk);
        ext_clk = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(dclk == 1'b1, "R3 fall too early", int'(dclk), 1);
        @(posedge clk);
        #1;
        chk(dclk == 1'b0, "R3 fall", int'(dclk), 0);
        ext_sel = 1'b0;
    endtask

    // R4 R5 R6 R7 R8 R9: acts as the converter over several frames
    task automatic t_frames(input bit f24, input bit hi, input logic [7:0] c0, input logic [7:0] c1,
                            input logic [11:0] w0, input logic [11:0] w1, input logic [11:0] w2);
        int          len;
        int          slot;
        int          frame;
        int          capj;
        int          done;
        logic [11:0] capw;
        logic [11:0] prevw;
        logic [7:0]  fcmd;
        logic        exp_din;
        logic [11:0] wl [3];
        wl[0] = w0; wl[1] = w1; wl[2] = w2;
        len   = f24 ? 24 : 16;
        slot  = -1;
        frame = -1;
        capj  = 14;
        done  = 0;
        capw  = '0;
        prevw = '0;
        fcmd  = c0;
        ext_sel    = 1'b0;
        div_hi     = hi;
        frame_long = f24;
        cmd        = c0;
        dout       = 1'b0;
        do_reset();
        while (done < 3) begin
            @(negedge dclk);
            #1;
            if (cs_n) begin
                if (slot == len - 1 && f24) begin
                    chk(1'b1, "R9 gap after slot 23", 1, 1);
                end else if (slot >= 0) begin
                    chk(1'b0, f24 ? "R9 early cs rise" : "R8 cs rose", slot, len - 1);
                end
                slot = -1;
            end else begin
                if (slot == -1 || slot == len - 1) begin
                    if (slot == len - 1) begin
                        chk(!f24, "R9 missing gap", 0, 1);
                        if (!f24) chk(cs_n == 1'b0, "R8 cs stays low", int'(cs_n), 0);
                    end
                    slot  = 0;
                    frame = frame + 1;
                    fcmd  = (frame == 0) ? c0 : c1;
                end else begin
                    slot++;
                end
                if (frame == 0 && slot == 3) cmd = c1;
                exp_din = (slot < 8) ? fcmd[7 - slot] : 1'b0;
                chk(din == exp_din, (frame > 0 && slot < 8) ? "R5 command reload" : "R4 command bit",
                    int'(din), int'(exp_din));
            end
            if (capj == 11) begin
                chk(dvalid == 1'b1, "R7 dvalid high", int'(dvalid), 1);
                chk(result == capw, "R6 result word", int'(result), int'(capw));
                prevw = capw;
                capj  = 12;
            end else if (capj == 12) begin
                chk(dvalid == 1'b0, "R7 dvalid one period", int'(dvalid), 0);
                chk(result == prevw, "R7 result holds", int'(result), int'(prevw));
                capj = 14;
                done++;
            end else if (capj < 11) begin
                capj++;
            end
            if (!cs_n && slot == 9) begin
                chk(result == prevw, "R7 result before update", int'(result), int'(prevw));
                capw = (frame < 3) ? wl[frame] : 12'h000;
                capj = 0;
            end
            dout = (capj <= 11) ? capw[11 - capj] : 1'b0;
        end
        dout = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        do_reset();
        t_divider(1'b0);
        t_divider(1'b1);
        t_external();
        t_frames(1'b0, 1'b0, 8'h97, 8'hD3, 12'hA5C, 12'h3F1, 12'h800);
        t_frames(1'b1, 1'b0, 8'h97, 8'h1E, 12'h001, 12'hFFF, 12'h6B4);
        t_frames(1'b0, 1'b1, 8'hC4, 8'h97, 12'h555, 12'hAAA, 12'h0F0);
        finish_run();
    end

endmodule